// File: doc/BRIEF.md
# ALU status flag register

This block is the processor status register that lives at one fixed data-memory address. It keeps the three ALU condition flags (zero, digit carry, carry), a program-memory page select bit, and two reset-cause bits: a time-out bit and a power-down bit. Software reads and writes it like any other register file location. The ALU, the watchdog and the sleep logic drive it through strobes. The block decides, bit by bit and cycle by cycle, who owns each bit.

A software write is masked per bit. When the same instruction also updates an ALU flag, that flag takes the ALU value and the write data for that bit is discarded. The time-out and power-down bits ignore writes entirely. They move only on power-up, watchdog clear, sleep entry and watchdog overflow.

A small state machine holds the two reset-cause bits, with the state encoded as {time-out, power-down}. There are four states:

- `CS_FRESH` (11) is reached from any state by power-up or watchdog clear.
- `CS_DOZE` (10) is reached by sleep entry without overflow.
- `CS_WDT_AWAKE` (01) is reached by an overflow while the power-down bit is 1 and no sleep strobe is present.
- `CS_WDT_DOZE` (00) is reached by an overflow from a state whose power-down bit is 0, or by an overflow together with sleep.

The ALU flags themselves are not computed here. For arithmetic, the ALU supplies carry out of bit 7 and bit 3, inverted for subtraction. For rotates, it supplies the bit shifted out. The page select bit is exported as the upper program-address bit: 0 selects 000h–1FFh and 1 selects 200h–3FFh.

Top module: `alu_flag_reg`

## Requirements
- R1: After reset, read bits 7..3 are 00011 (bits 7:6 zero, page 0, time-out 1, power-down 1) and page_sel is 0. The ALU flags in bits 2..0 are unspecified.
- R2: Read bits 7 and 6 are always 0, whatever is written.
- R3: A write with wr_addr equal to STATUS_ADDR (default 3) and no update strobes loads page select from wr_data bit 5, zero from bit 2, digit carry from bit 1 and carry from bit 0. A write to any other address changes nothing.
- R4: Writes never change the time-out bit (bit 4) or the power-down bit (bit 3).
- R5: While a flag's update strobe (upd_z, upd_dc, upd_c) is high, the next cycle's flag equals the ALU value, even during a write. In that write, the bits without a strobe still take the write data.
- R6: Power-up or watchdog clear sets both time-out and power-down, and this beats sleep and overflow in the same cycle.
- R7: Sleep entry alone sets time-out and clears power-down.
- R8: Watchdog overflow clears time-out and leaves power-down unchanged. Overflow together with sleep gives time-out 0 and power-down 0.
- R9: page_sel always equals read bit 5.
- R10: With no write hit, no strobe and no event, every bit holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register-file write enable |
| wr_addr | input | ADDR_W | Register-file write address |
| wr_data | input | 8 | Register-file write data |
| alu_z | input | 1 | ALU zero result |
| alu_dc | input | 1 | ALU digit carry result |
| alu_c | input | 1 | ALU carry result |
| upd_z | input | 1 | Update strobe for zero |
| upd_dc | input | 1 | Update strobe for digit carry |
| upd_c | input | 1 | Update strobe for carry |
| ev_powerup | input | 1 | Power-up event |
| ev_wdt_clear | input | 1 | Watchdog clear event |
| ev_sleep | input | 1 | Sleep entry event |
| ev_wdt_ovf | input | 1 | Watchdog overflow event |
| rd_data | output | 8 | Register value |
| page_sel | output | 1 | Program page select |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is a software write to the register and an ALU flag update. The bench drives a write of all-ones data with some update strobes high and zero ALU values. It then checks that only the strobed bits took the ALU values, while the others took the write data.

The second pair is two reset-cause events at once: sleep with overflow, and power-up with overflow or clear with sleep. The bench applies each pair in a single cycle and compares the resulting {time-out, power-down} against the priority in R6 and R8.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;
    localparam int DATA_W   = 8;
    localparam int FLAG_N   = 3;
    localparam int BIT_C    = 0;
    localparam int BIT_DC   = 1;
    localparam int BIT_Z    = 2;
    localparam int BIT_PD   = 3;
    localparam int BIT_TO   = 4;
    localparam int BIT_PAGE = 5;

    // encoding is {time_out, power_down}
    typedef enum logic [1:0] {
        CS_WDT_DOZE  = 2'b00,
        CS_WDT_AWAKE = 2'b01,
        CS_DOZE      = 2'b10,
        CS_FRESH     = 2'b11
    } cause_e;
endpackage

// File: rtl/status_write_decode.sv
module status_write_decode #(
    parameter int ADDR_W      = 5,
    parameter int STATUS_ADDR = 3,
    parameter int FLAG_N      = 3
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [FLAG_N-1:0] upd,
    output logic              wr_hit,
    output logic [FLAG_N-1:0] flag_wr
);
    localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(STATUS_ADDR);

    always_comb begin
        wr_hit  = wr_en && (wr_addr == HIT_ADDR);
        flag_wr = {FLAG_N{wr_hit}} & ~upd;
    end
endmodule

// File: rtl/flag_bank.sv
module flag_bank #(
    parameter int FLAG_N = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [FLAG_N-1:0] flag_wr,
    input  logic [FLAG_N-1:0] wr_bits,
    input  logic [FLAG_N-1:0] upd,
    input  logic [FLAG_N-1:0] alu_bits,
    input  logic              page_bit,
    output logic [FLAG_N-1:0] flag_q,
    output logic              page_q
);
    for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)          flag_q[i] <= 1'b0;
            else if (upd[i])     flag_q[i] <= alu_bits[i];
            else if (flag_wr[i]) flag_q[i] <= wr_bits[i];
        end

        a_r5_alu_wins: assert property (@(posedge clk) disable iff (!rst_n)
            upd[i] |=> flag_q[i] == $past(alu_bits[i]));
        a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_hit && !upd[i]) |=> flag_q[i] == $past(wr_bits[i]));
        a_r10_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!wr_hit && !upd[i]) |=> $stable(flag_q[i]));
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      page_q <= 1'b0;
        else if (wr_hit) page_q <= page_bit;
    end
endmodule

// File: rtl/cause_tracker.sv
module cause_tracker
    import alu_flag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ev_powerup,
    input  logic ev_wdt_clear,
    input  logic ev_sleep,
    input  logic ev_wdt_ovf,
    output logic time_out,
    output logic power_down
);
    cause_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CS_FRESH;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (ev_powerup || ev_wdt_clear) begin
            state_d = CS_FRESH;
        end else if (ev_wdt_ovf) begin
            unique case (state_q)
                CS_FRESH, CS_WDT_AWAKE:
                    state_d = ev_sleep ? CS_WDT_DOZE : CS_WDT_AWAKE;
                CS_DOZE, CS_WDT_DOZE:
                    state_d = CS_WDT_DOZE;
            endcase
        end else if (ev_sleep) begin
            state_d = CS_DOZE;
        end
    end

    always_comb begin
        unique case (state_q)
            CS_FRESH:     {time_out, power_down} = 2'b11;
            CS_DOZE:      {time_out, power_down} = 2'b10;
            CS_WDT_AWAKE: {time_out, power_down} = 2'b01;
            CS_WDT_DOZE:  {time_out, power_down} = 2'b00;
        endcase
    end

    a_r6_wake_sets_both: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_powerup || ev_wdt_clear) |=> (time_out && power_down));
    a_r7_sleep_alone: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_sleep && !ev_wdt_ovf && !ev_powerup && !ev_wdt_clear)
        |=> (time_out && !power_down));
    a_r8_ovf_clears_to: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_wdt_ovf && !ev_powerup && !ev_wdt_clear) |=> !time_out);
    a_r8_ovf_keeps_pd: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_wdt_ovf && !ev_sleep && !ev_powerup && !ev_wdt_clear)
        |=> $stable(power_down));
    a_r4_cause_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_wdt_ovf && !ev_sleep && !ev_powerup && !ev_wdt_clear)
        |=> $stable({time_out, power_down}));
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
    import alu_flag_pkg::*;
#(
    parameter int ADDR_W      = 5,
    parameter int STATUS_ADDR = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              alu_z,
    input  logic              alu_dc,
    input  logic              alu_c,
    input  logic              upd_z,
    input  logic              upd_dc,
    input  logic              upd_c,
    input  logic              ev_powerup,
    input  logic              ev_wdt_clear,
    input  logic              ev_sleep,
    input  logic              ev_wdt_ovf,
    output logic [7:0]        rd_data,
    output logic              page_sel
);
    logic              wr_hit;
    logic [FLAG_N-1:0] upd, alu_bits, wr_bits, flag_wr, flag_q;
    logic              page_q, time_out, power_down;
    logic              unused_wr_bits;

    assign upd            = {upd_z, upd_dc, upd_c};
    assign alu_bits       = {alu_z, alu_dc, alu_c};
    assign wr_bits        = {wr_data[BIT_Z], wr_data[BIT_DC], wr_data[BIT_C]};
    assign unused_wr_bits = ^{wr_data[7:6], wr_data[BIT_TO], wr_data[BIT_PD]};

    status_write_decode #(
        .ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR), .FLAG_N(FLAG_N)
    ) u_decode (
        .wr_en(wr_en), .wr_addr(wr_addr), .upd(upd),
        .wr_hit(wr_hit), .flag_wr(flag_wr)
    );

    flag_bank #(.FLAG_N(FLAG_N)) u_flags (
        .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .flag_wr(flag_wr),
        .wr_bits(wr_bits), .upd(upd), .alu_bits(alu_bits),
        .page_bit(wr_data[BIT_PAGE]), .flag_q(flag_q), .page_q(page_q)
    );

    cause_tracker u_cause (
        .clk(clk), .rst_n(rst_n), .ev_powerup(ev_powerup),
        .ev_wdt_clear(ev_wdt_clear), .ev_sleep(ev_sleep),
        .ev_wdt_ovf(ev_wdt_ovf), .time_out(time_out), .power_down(power_down)
    );

    always_comb begin
        rd_data           = '0;
        rd_data[BIT_PAGE] = page_q;
        rd_data[BIT_TO]   = time_out;
        rd_data[BIT_PD]   = power_down;
        rd_data[BIT_Z]    = flag_q[2];
        rd_data[BIT_DC]   = flag_q[1];
        rd_data[BIT_C]    = flag_q[0];
        page_sel          = page_q;
    end

    a_r2_top_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[7:6] == 2'b00);
    a_r4_write_no_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !ev_powerup && !ev_wdt_clear && !ev_sleep && !ev_wdt_ovf)
        |=> $stable({rd_data[BIT_TO], rd_data[BIT_PD]}));
endmodule

// File: tb/alu_flag_reg_tb.sv
module alu_flag_reg_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [4:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic alu_z = 0, alu_dc = 0, alu_c = 0;
    logic upd_z = 0, upd_dc = 0, upd_c = 0;
    logic ev_powerup = 0, ev_wdt_clear = 0, ev_sleep = 0, ev_wdt_ovf = 0;
    logic [7:0] rd_data;
    logic       page_sel;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    alu_flag_reg u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .alu_z(alu_z), .alu_dc(alu_dc), .alu_c(alu_c),
        .upd_z(upd_z), .upd_dc(upd_dc), .upd_c(upd_c),
        .ev_powerup(ev_powerup), .ev_wdt_clear(ev_wdt_clear),
        .ev_sleep(ev_sleep), .ev_wdt_ovf(ev_wdt_ovf),
        .rd_data(rd_data), .page_sel(page_sel)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic idle_inputs();
        wr_en = 0; wr_addr = '0; wr_data = '0;
        {alu_z, alu_dc, alu_c} = '0; {upd_z, upd_dc, upd_c} = '0;
        {ev_powerup, ev_wdt_clear, ev_sleep, ev_wdt_ovf} = '0;
    endtask

    // inputs set at a falling edge; one rising edge; sample at next falling edge
    task automatic tick();
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic do_write(input logic [4:0] a, input logic [7:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        tick();
    endtask

    task automatic t_reset();
        chk("R1 reset upper bits", {rd_data[7:3], 3'b000}, 8'h18);
        chk("R1 reset page_sel", {7'd0, page_sel}, 8'h00);
    endtask

    task automatic t_write();
        do_write(5'd3, 8'hFF);
        chk("R3/R4 write all ones", rd_data, 8'h3F);
        chk("R2 top bits zero", {6'd0, rd_data[7:6]}, 8'h00);
        chk("R9 page_sel high", {7'd0, page_sel}, {7'd0, rd_data[5]});
        do_write(5'd3, 8'h00);
        chk("R4 write zeros keeps cause bits", rd_data, 8'h18);
        chk("R9 page_sel low", {7'd0, page_sel}, 8'h00);
        do_write(5'd4, 8'hFF);
        chk("R3 other address ignored", rd_data, 8'h18);
    endtask

    task automatic t_update();
        wr_en = 1; wr_addr = 5'd3; wr_data = 8'h27;
        upd_z = 1; alu_z = 0; upd_c = 1; alu_c = 0;
        tick();
        chk("R5 ALU beats write data", rd_data, 8'h3A);
        upd_dc = 1; alu_dc = 0;
        tick();
        chk("R5 update without write", rd_data, 8'h38);
        tick();
        chk("R10 idle holds", rd_data, 8'h38);
    endtask

    task automatic t_events();
        ev_sleep = 1; tick();
        chk("R7 sleep", rd_data, 8'h30);
        do_write(5'd3, 8'h18);
        chk("R4 write cannot set power-down", rd_data, 8'h10);
        ev_wdt_ovf = 1; tick();
        chk("R8 overflow while asleep", rd_data, 8'h00);
        ev_wdt_clear = 1; tick();
        chk("R6 watchdog clear", rd_data, 8'h18);
        ev_wdt_ovf = 1; tick();
        chk("R8 overflow keeps power-down", rd_data, 8'h08);
        ev_wdt_clear = 1; tick();
        ev_sleep = 1; ev_wdt_ovf = 1; tick();
        chk("R8 overflow with sleep", rd_data, 8'h00);
        ev_powerup = 1; ev_wdt_ovf = 1; tick();
        chk("R6 power-up beats overflow", rd_data, 8'h18);
        ev_wdt_clear = 1; ev_sleep = 1; tick();
        chk("R6 clear beats sleep", rd_data, 8'h18);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_write();
        t_update();
        t_events();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired: got 0 expected 1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule